// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps a table of interrupt sources. Each source is fixed at build time as either level-sensitive or message-style (edge-triggered). For every source it stores a target server, a priority, a saved priority and a small set of status bits. It turns activity on the source input lines into presentation requests. Each request carries a global source number, a server and a priority, and goes to a downstream presentation unit. That unit can answer with a reject, an end-of-interrupt (EOI) or a request to resend. The block updates its per-source status from each answer.

A configuration write port sets a source's server, priority and saved priority. A priority of 0xFF means the source is masked. A message source that fires while masked is parked, and a configuration write that unmasks it releases the parked request. A resend walks the whole table one source per cycle and re-offers anything that was rejected or is still waiting. Global source numbers are the local index plus a base offset; numbers outside the table are ignored.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset, every priority and saved priority is 0xFF (masked), all status bits are clear, `req_valid` and `resend_busy` are low, and the level/message type of each source is unchanged.
- R2: A message source whose priority is not 0xFF issues one request on a 0-to-1 transition of its line. The request carries number BASE+index, the source's server and its priority.
- R3: A message source that sees a 0-to-1 transition while its priority is 0xFF issues nothing and records a masked-pending flag. A later configuration write with a priority other than 0xFF clears the flag and issues the request.
- R4: On a change of its line, a level source sets its asserted flag to the line value. It then issues a request only if its priority is not 0xFF, asserted is set and sent is clear. Issuing sets sent, so no second request follows while sent stays set.
- R5: A reject for a message source sets its rejected flag. The next resend scan clears the flag and issues the request again if the priority is not 0xFF; a second scan issues nothing.
- R6: A reject for a level source clears sent, so the next resend scan issues again while the line is still high.
- R7: An EOI for a level source clears sent. An EOI for a message source changes nothing: a following scan issues no request for it.
- R8: A configuration write updates server, priority and saved priority, and re-runs the send check for a level source.
- R9: Reject, EOI and configuration numbers map to local index number-BASE. A number below BASE or at or above BASE+NUM_SRC has no effect.
- R10: At most one request is issued per cycle. Among waiting sources the lowest index goes first, and the others follow on later cycles.
- R11: A resend pulse while idle raises `resend_busy` for exactly NUM_SRC cycles, visiting one source per cycle. A resend pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_SRC | Source input lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_num | input | NUM_W | Global number of the source written |
| cfg_srv | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject strobe from the presentation unit |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | EOI strobe |
| eoi_num | input | NUM_W | Global number completed |
| resend_req | input | 1 | Start a resend scan |
| req_valid | output | 1 | A presentation request is offered this cycle |
| req_num | output | NUM_W | Global source number of the request |
| req_srv | output | SRV_W | Target server of the request |
| req_prio | output | 8 | Priority of the request |
| resend_busy | output | 1 | Resend scan in progress |

## Verification
The bench builds the block with four sources, sources 1 and 3 level-sensitive and sources 0 and 2 message-style, with base 0x1000. This mix puts both state rule sets side by side. It also lets two message sources fire in the same cycle, which exercises request ordering. A full resend scan takes only four cycles, so a second resend pulse can land inside a running scan. Numbers just below the base and just past the table (0x0FFF and 0x1004) probe the range check. A behavioural model is compared with the outputs on every clock.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
  localparam logic [7:0] PRIO_OFF = 8'hFF;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
  } src_stat_t;

  function automatic logic lvl_can_send(src_stat_t s, logic [7:0] p);
    return (p != PRIO_OFF) && s.asserted && !s.sent;
  endfunction
endpackage

// File: rtl/irqsrc_entry.sv
module irqsrc_entry
  import irqsrc_pkg::*;
#(
  parameter int   SRV_W    = 4,
  parameter logic IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             rej_i,
  input  logic             eoi_i,
  input  logic             cfg_i,
  input  logic [SRV_W-1:0] cfg_srv_i,
  input  logic [7:0]       cfg_prio_i,
  input  logic [7:0]       cfg_saved_i,
  input  logic             scan_i,
  input  logic             grant_i,
  output logic             pend_o,
  output logic [SRV_W-1:0] srv_o,
  output logic [7:0]       prio_o
);
  src_stat_t        st_q, st_n;
  logic [7:0]       prio_q, prio_n, saved_q, saved_n;
  logic [SRV_W-1:0] srv_q, srv_n;
  logic             pend_q, pend_n, line_q, send;

  always_comb begin
    st_n    = st_q;
    prio_n  = prio_q;
    saved_n = saved_q;
    srv_n   = srv_q;
    send    = 1'b0;
    if (rej_i) begin
      if (IS_LEVEL) st_n.sent = 1'b0;
      else          st_n.rejected = 1'b1;
    end
    if (eoi_i && IS_LEVEL) st_n.sent = 1'b0;
    if (IS_LEVEL) begin
      if (line_i != line_q) begin
        st_n.asserted = line_i;
        if (lvl_can_send(st_n, prio_n)) begin st_n.sent = 1'b1; send = 1'b1; end
      end
    end else if (line_i && !line_q) begin
      if (prio_n == PRIO_OFF) st_n.mpend = 1'b1;
      else                    send = 1'b1;
    end
    if (cfg_i) begin
      srv_n   = cfg_srv_i;
      prio_n  = cfg_prio_i;
      saved_n = cfg_saved_i;
      if (IS_LEVEL) begin
        if (lvl_can_send(st_n, prio_n)) begin st_n.sent = 1'b1; send = 1'b1; end
      end else if (st_n.mpend && prio_n != PRIO_OFF) begin
        st_n.mpend = 1'b0;
        send       = 1'b1;
      end
    end
    if (scan_i) begin
      if (IS_LEVEL) begin
        if (lvl_can_send(st_n, prio_n)) begin st_n.sent = 1'b1; send = 1'b1; end
      end else if (st_n.rejected) begin
        st_n.rejected = 1'b0;
        if (prio_n != PRIO_OFF) send = 1'b1;
      end
    end
    pend_n = (pend_q & ~grant_i) | send;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      prio_q  <= PRIO_OFF;
      saved_q <= PRIO_OFF;
      srv_q   <= '0;
      pend_q  <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      line_q <= line_i;
      if (cfg_i) begin
        prio_q  <= prio_n;
        saved_q <= saved_n;
        srv_q   <= srv_n;
      end
    end
  end

  assign pend_o = pend_q;
  assign srv_o  = srv_q;
  assign prio_o = prio_q;

  // R4
  sent_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.sent) |-> (st_q.asserted && prio_q != PRIO_OFF));
  // R3
  mpend_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.mpend |-> (prio_q == PRIO_OFF));
  // R8
  saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i |=> $stable(saved_q));
  // R5
  kind_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    IS_LEVEL |-> (!st_q.rejected && !st_q.mpend));
endmodule

// File: rtl/irqsrc_issue.sv
module irqsrc_issue #(
  parameter int                NUM_SRC = 8,
  parameter int                SRV_W   = 4,
  parameter int                NUM_W   = 16,
  parameter logic [NUM_W-1:0]  BASE    = 16'h1000,
  localparam int               IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_SRC*SRV_W-1:0] srv_i,
  input  logic [NUM_SRC*8-1:0]     prio_i,
  output logic [NUM_SRC-1:0]       grant_o,
  output logic                     req_valid,
  output logic [NUM_W-1:0]         req_num,
  output logic [SRV_W-1:0]         req_srv,
  output logic [7:0]               req_prio
);
  logic [IDX_W-1:0] sel;
  logic             found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        sel   = IDX_W'(i);
        found = 1'b1;
      end
    end
    grant_o = found ? (NUM_SRC'(1) << sel) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_num   <= '0;
      req_srv   <= '0;
      req_prio  <= '0;
    end else begin
      req_valid <= found;
      if (found) begin
        req_num  <= BASE + NUM_W'(sel);
        req_srv  <= srv_i[sel*SRV_W +: SRV_W];
        req_prio <= prio_i[sel*8 +: 8];
      end
    end
  end

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R10
  grant_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |=> req_valid);
  // R9
  num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_num >= BASE && req_num < BASE + NUM_W'(NUM_SRC)));
endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan #(
  parameter int  NUM_SRC = 8,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int LAST    = NUM_SRC - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  output logic               busy_o,
  output logic [NUM_SRC-1:0] hit_o
);
  logic             busy_q, busy_n;
  logic [IDX_W-1:0] idx_q, idx_n;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    if (busy_q) begin
      if (idx_q == IDX_W'(LAST)) begin
        busy_n = 1'b0;
        idx_n  = '0;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end else if (start_i) begin
      busy_n = 1'b1;
      idx_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
    end
  end

  assign busy_o = busy_q;
  assign hit_o  = busy_q ? (NUM_SRC'(1) << idx_q) : '0;

  // R11
  scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q == IDX_W'(LAST)) |=> !busy_q);
  // R11
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && idx_q == '0));
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl #(
  parameter int                 NUM_SRC    = 8,
  parameter int                 SRV_W      = 4,
  parameter int                 NUM_W      = 16,
  parameter logic [NUM_W-1:0]   BASE       = 16'h1000,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hAA
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] line_in,
  input  logic               cfg_we,
  input  logic [NUM_W-1:0]   cfg_num,
  input  logic [SRV_W-1:0]   cfg_srv,
  input  logic [7:0]         cfg_prio,
  input  logic [7:0]         cfg_saved,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend_req,
  output logic               req_valid,
  output logic [NUM_W-1:0]   req_num,
  output logic [SRV_W-1:0]   req_srv,
  output logic [7:0]         req_prio,
  output logic               resend_busy
);
  logic [NUM_SRC-1:0]       pend, grant, scan_hit;
  logic [NUM_SRC*SRV_W-1:0] srv_flat;
  logic [NUM_SRC*8-1:0]     prio_flat;

  function automatic logic num_hit(logic [NUM_W-1:0] n, int idx);
    logic [NUM_W-1:0] off;
    off = n - BASE;
    return (n >= BASE) && (off == NUM_W'(idx));
  endfunction

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      irqsrc_entry #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MASK[g])) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_in[g]),
        .rej_i      (rej_valid && num_hit(rej_num, g)),
        .eoi_i      (eoi_valid && num_hit(eoi_num, g)),
        .cfg_i      (cfg_we && num_hit(cfg_num, g)),
        .cfg_srv_i  (cfg_srv),
        .cfg_prio_i (cfg_prio),
        .cfg_saved_i(cfg_saved),
        .scan_i     (scan_hit[g]),
        .grant_i    (grant[g]),
        .pend_o     (pend[g]),
        .srv_o      (srv_flat[g*SRV_W +: SRV_W]),
        .prio_o     (prio_flat[g*8 +: 8])
      );
    end
  endgenerate

  irqsrc_issue #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .srv_i    (srv_flat),
    .prio_i   (prio_flat),
    .grant_o  (grant),
    .req_valid(req_valid),
    .req_num  (req_num),
    .req_srv  (req_srv),
    .req_prio (req_prio)
  );

  irqsrc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(resend_req),
    .busy_o (resend_busy),
    .hit_o  (scan_hit)
  );
endmodule

// File: tb/irq_source_ctrl_test.sv
module irq_source_ctrl_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 4;
  localparam int          SW         = 4;
  localparam int          NW         = 16;
  localparam int          BASE       = 'h1000;
  localparam logic [N-1:0] LVL       = 4'b1010;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] line_in = '0;
  logic cfg_we = 0, rej_valid = 0, eoi_valid = 0, resend_req = 0;
  logic [NW-1:0] cfg_num = '0, rej_num = '0, eoi_num = '0;
  logic [SW-1:0] cfg_srv = '0;
  logic [7:0] cfg_prio = '0, cfg_saved = '0;
  logic req_valid, resend_busy;
  logic [NW-1:0] req_num;
  logic [SW-1:0] req_srv;
  logic [7:0] req_prio;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int log_q[$];

  irq_source_ctrl #(.NUM_SRC(N), .SRV_W(SW), .NUM_W(NW), .BASE(16'h1000), .LEVEL_MASK(LVL)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_we(cfg_we), .cfg_num(cfg_num),
    .cfg_srv(cfg_srv), .cfg_prio(cfg_prio), .cfg_saved(cfg_saved), .rej_valid(rej_valid),
    .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
    .req_valid(req_valid), .req_num(req_num), .req_srv(req_srv), .req_prio(req_prio),
    .resend_busy(resend_busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_prio[N], m_srv[N];
  bit m_as[N], m_sent[N], m_rej[N], m_mp[N], m_pend[N], m_lq[N];
  bit m_busy, m_rv;
  int m_idx, m_rn, m_rs, m_rp;

  function automatic bit lvl_try(int i);
    if (m_prio[i] != 255 && m_as[i] && !m_sent[i]) begin m_sent[i] = 1; return 1; end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_prio[i] = 255; m_srv[i] = 0; m_as[i] = 0; m_sent[i] = 0;
        m_rej[i] = 0; m_mp[i] = 0; m_pend[i] = 0; m_lq[i] = 0;
      end
      m_busy = 0; m_idx = 0; m_rv = 0; m_rn = 0; m_rs = 0; m_rp = 0;
    end else begin
      int k, sh;
      k = -1;
      for (int i = 0; i < N; i++) if (m_pend[i] && k < 0) k = i;
      m_rv = (k >= 0);
      if (k >= 0) begin m_rn = BASE + k; m_rs = m_srv[k]; m_rp = m_prio[k]; m_pend[k] = 0; end
      sh = m_busy ? m_idx : -1;
      if (m_busy) begin
        if (m_idx == N - 1) begin m_busy = 0; m_idx = 0; end else m_idx++;
      end else if (resend_req) begin m_busy = 1; m_idx = 0; end
      for (int i = 0; i < N; i++) begin
        bit s;
        s = 0;
        if (rej_valid && int'(rej_num) == BASE + i) begin
          if (LVL[i]) m_sent[i] = 0; else m_rej[i] = 1;
        end
        if (eoi_valid && int'(eoi_num) == BASE + i && LVL[i]) m_sent[i] = 0;
        if (LVL[i]) begin
          if (line_in[i] != m_lq[i]) begin m_as[i] = line_in[i]; s |= lvl_try(i); end
        end else if (line_in[i] && !m_lq[i]) begin
          if (m_prio[i] == 255) m_mp[i] = 1; else s = 1;
        end
        if (cfg_we && int'(cfg_num) == BASE + i) begin
          m_srv[i] = int'(cfg_srv); m_prio[i] = int'(cfg_prio);
          if (LVL[i]) s |= lvl_try(i);
          else if (m_mp[i] && m_prio[i] != 255) begin m_mp[i] = 0; s = 1; end
        end
        if (sh == i) begin
          if (LVL[i]) s |= lvl_try(i);
          else if (m_rej[i]) begin m_rej[i] = 0; if (m_prio[i] != 255) s = 1; end
        end
        m_lq[i] = line_in[i];
        if (s) m_pend[i] = 1;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model, and request logging
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(req_valid == m_rv, "R10 req_valid vs model", req_valid, m_rv);
      check(resend_busy == m_busy, "R11 resend_busy vs model", resend_busy, m_busy);
      if (req_valid && m_rv) begin
        check(int'(req_num) == m_rn, "R2 req_num vs model", req_num, m_rn);
        check(int'(req_srv) == m_rs, "R2 req_srv vs model", req_srv, m_rs);
        check(int'(req_prio) == m_rp, "R2 req_prio vs model", req_prio, m_rp);
      end
      if (req_valid) log_q.push_back((int'(req_num) << 16) | (int'(req_srv) << 8) | int'(req_prio));
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cfg(int num, int srv, int prio);
    @(negedge clk);
    cfg_we = 1; cfg_num = NW'(num); cfg_srv = SW'(srv); cfg_prio = 8'(prio); cfg_saved = 8'(prio);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_rej(int num);
    @(negedge clk); rej_valid = 1; rej_num = NW'(num);
    @(negedge clk); rej_valid = 0;
  endtask

  task automatic do_eoi(int num);
    @(negedge clk); eoi_valid = 1; eoi_num = NW'(num);
    @(negedge clk); eoi_valid = 0;
  endtask

  task automatic do_resend();
    @(negedge clk); resend_req = 1;
    @(negedge clk); resend_req = 0;
    wait_n(N + 4);
  endtask

  task automatic set_line(int i, bit v);
    @(negedge clk); line_in[i] = v;
    wait_n(4);
  endtask

  task automatic expect_log(string tag, int cnt, int first);
    check(log_q.size() == cnt, {tag, " count"}, log_q.size(), cnt);
    if (cnt > 0 && log_q.size() > 0) check(log_q[0] == first, {tag, " content"}, log_q[0], first);
    log_q.delete();
  endtask

  initial begin
    int busy_cycles;
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1 reset state
    check(req_valid == 0, "R1 req_valid after reset", req_valid, 0);
    check(resend_busy == 0, "R1 resend_busy after reset", resend_busy, 0);
    log_q.delete();
    // R1 / R3: masked message source parks
    set_line(0, 1);
    expect_log("R1 R3 masked edge", 0, 0);
    do_cfg('h1000, 3, 5);
    wait_n(4);
    expect_log("R3 release on unmask", 1, 'h10000305);
    // R2 message edge
    set_line(0, 0);
    set_line(0, 1);
    expect_log("R2 message edge", 1, 'h10000305);
    // R4 level source
    do_cfg('h1001, 2, 7);
    wait_n(4);
    expect_log("R4 level idle cfg", 0, 0);
    set_line(1, 1);
    expect_log("R4 level assert", 1, 'h10010207);
    set_line(1, 0);
    set_line(1, 1);
    expect_log("R4 no repeat while sent", 0, 0);
    // R7 / R8: EOI clears sent, cfg rechecks
    do_eoi('h1001);
    wait_n(4);
    expect_log("R7 level eoi no auto send", 0, 0);
    do_cfg('h1001, 2, 6);
    wait_n(4);
    expect_log("R8 cfg recheck", 1, 'h10010206);
    // R6 level reject then resend
    do_rej('h1001);
    do_resend();
    expect_log("R6 level reject resend", 1, 'h10010206);
    // R5 message reject then resend
    do_rej('h1000);
    do_resend();
    expect_log("R5 message reject resend", 1, 'h10000305);
    do_resend();
    expect_log("R5 second scan empty", 0, 0);
    // R7 message EOI no effect
    do_eoi('h1000);
    do_resend();
    expect_log("R7 message eoi ignored", 0, 0);
    // R9 mapping and out-of-range
    do_cfg('h1002, 9, 4);
    do_cfg('h1004, 0, 255);
    do_cfg('h0FFF, 0, 255);
    do_rej('h1004);
    do_eoi('h0FFF);
    wait_n(4);
    expect_log("R9 out of range quiet", 0, 0);
    set_line(0, 0);
    @(negedge clk); line_in[0] = 1; line_in[2] = 1;
    wait_n(5);
    // R10 ordering: lowest index first, both delivered
    check(log_q.size() == 2, "R10 two requests", log_q.size(), 2);
    if (log_q.size() == 2) begin
      check(log_q[0] == 'h10000305, "R10 first low index", log_q[0], 'h10000305);
      check(log_q[1] == 'h10020904, "R9 R10 second mapped", log_q[1], 'h10020904);
    end
    log_q.delete();
    // R11 busy length with repeated pulse
    @(negedge clk); resend_req = 1;
    @(negedge clk); resend_req = 0;
    busy_cycles = 1;
    @(negedge clk); resend_req = 1;
    if (resend_busy) busy_cycles++;
    @(negedge clk); resend_req = 0;
    for (int j = 0; j < 2 * N; j++) begin
      if (resend_busy) busy_cycles++;
      @(negedge clk);
    end
    check(busy_cycles == N, "R11 busy length", busy_cycles, N);
    wait_n(4);
    log_q.delete();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule